// File: doc/BRIEF.md
# Status Register Interrupt Pending Controller

This block keeps a 32-bit processor status word in which the interrupt bookkeeping sits: the top byte holds eight pending flags and the byte beneath it holds the eight matching mask flags. Three hardware events update the pending flags, and each one arrives through a write to some other control register: a timer match, an inter-processor message and a host message. A free-running count register and a compare register supply the timer match. The pending flags are therefore side effects held in the status word, with no separate pending register.

Software reaches the registers through one indexed write port and one indexed combinational read port. The block ANDs the pending byte with the mask byte and gates the result with the global enable bit. It drives an interrupt request and the number of the winning line, which trap-entry logic elsewhere consumes.

Top module: `intr_status_ctl`

## Requirements
- R1: Status register (index 0) stores bits 8:0 and bits 31:16 on a write. Bits 15:9 always read as zero and ignore written ones.
- R2: `irq_req` is 1 exactly when status bit 0 (global enable) is set and the AND of pending bits 31:24 with mask bits 23:16 is nonzero.
- R3: `irq_line` gives the highest-numbered line that is both pending and masked in, and is 0 while `irq_req` is low. Line 7 (timer) beats line 6 (host), and line 6 beats line 5 (inter-processor).
- R4: The count register (index 4) increments by one every clock. A write loads it, and the written value reads back one cycle later.
- R5: Timer pending (status bit 31) is set on the clock where count moves from a value below compare to a value at or above compare. The wrap from all-ones to zero never sets it.
- R6: A write to compare (index 5) stores the value and clears status bit 31.
- R7: A write to the inter-processor clear register (index 8) copies data bit 0 into status bit 29.
- R8: A write to the host-message register (index 31) stores the value and sets status bit 30 if the value is nonzero, or clears it if the value is zero.
- R9: When a timer match and a status write fall on the same clock, the timer bit is applied on top of the written value.
- R10: After reset, status, compare and host-message read as zero and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Register index for the read |
| rd_data | output | 32 | Read data, combinational from `rd_idx` |
| irq_req | output | 1 | Interrupt request |
| irq_line | output | 3 | Number of the selected interrupt line |

## Verification
The assertions check the following on every cycle:
- the count steps by one whenever it is not written;
- the reserved status bits stay zero;
- a timer hit lands in the timer pending bit;
- compare, inter-processor and host writes drive their pending bits as specified;
- the reported line is always both pending and enabled, and the timer wins whenever it is live.

Only the bench's scenarios can show the exact cycle of a compare crossing, including the absence of a match across the count wrap. They also show the ordering when a status write and a timer match coincide, and the readback of stored values through the read port.

// File: rtl/intr_status_pkg.sv
package intr_status_pkg;
  localparam int XLEN      = 32;
  localparam int IRQ_N     = 8;
  localparam int IRQ_W     = $clog2(IRQ_N);
  localparam int IDX_W     = 5;
  localparam int MASK_LSB  = 16;
  localparam int PEND_LSB  = 24;
  localparam int ET_BIT    = 0;

  localparam int IRQ_IPI   = 5;
  localparam int IRQ_HOST  = 6;
  localparam int IRQ_TIMER = 7;

  localparam logic [IDX_W-1:0] REG_STATUS  = 5'd0;
  localparam logic [IDX_W-1:0] REG_COUNT   = 5'd4;
  localparam logic [IDX_W-1:0] REG_COMPARE = 5'd5;
  localparam logic [IDX_W-1:0] REG_IPI_CLR = 5'd8;
  localparam logic [IDX_W-1:0] REG_HOST_IN = 5'd31;

  // Defined status fields: enable and mode bits 8:0, mask byte, pending byte
  localparam logic [XLEN-1:0] STATUS_KEEP = 32'hFFFF_01FF;

  function automatic logic [XLEN-1:0] status_clean(input logic [XLEN-1:0] v);
    return v & STATUS_KEEP;
  endfunction

  // True when stepping prev by one moves it from below cmp to at-or-above cmp.
  function automatic logic count_crossed(input logic [XLEN-1:0] prev,
                                         input logic [XLEN-1:0] cmp);
    logic [XLEN:0] nxt;
    nxt = {1'b0, prev} + {{XLEN{1'b0}}, 1'b1};
    return (prev < cmp) && (nxt >= {1'b0, cmp});
  endfunction

  function automatic logic [IRQ_W-1:0] top_index(input logic [IRQ_N-1:0] v);
    logic [IRQ_W-1:0] r;
    r = '0;
    for (int i = 0; i < IRQ_N; i++) begin
      if (v[i]) r = IRQ_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/ic_timer.sv
module ic_timer
  import intr_status_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_wr,
  input  logic            cmp_wr,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] count_o,
  output logic [XLEN-1:0] cmp_o,
  output logic            timer_hit
);
  logic [XLEN-1:0] count_q;
  logic [XLEN-1:0] cmp_q;

  assign timer_hit = !cnt_wr && count_crossed(count_q, cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cmp_q   <= '0;
    end else begin
      if (cnt_wr) count_q <= wr_data;
      else        count_q <= count_q + 1'b1;
      if (cmp_wr) cmp_q <= wr_data;
    end
  end

  assign count_o = count_q;
  assign cmp_o   = cmp_q;

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cnt_wr)) |-> (count_q == $past(count_q) + 1'b1));

  p_count_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == $past(wr_data)));
endmodule

// File: rtl/ic_status.sv
module ic_status
  import intr_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             status_wr,
  input  logic             ipi_wr,
  input  logic             host_wr,
  input  logic             cmp_wr,
  input  logic             timer_hit,
  input  logic [XLEN-1:0]  wr_data,
  output logic [XLEN-1:0]  status_o,
  output logic [XLEN-1:0]  host_o,
  output logic [IRQ_N-1:0] pend_o,
  output logic [IRQ_N-1:0] mask_o,
  output logic             et_o
);
  localparam int T_BIT = PEND_LSB + IRQ_TIMER;
  localparam int I_BIT = PEND_LSB + IRQ_IPI;
  localparam int H_BIT = PEND_LSB + IRQ_HOST;

  logic [XLEN-1:0] status_q, status_d;
  logic [XLEN-1:0] host_q;

  // Software write first, then event side effects on top of it
  always_comb begin
    status_d = status_q;
    if (status_wr) status_d = status_clean(wr_data);
    if (timer_hit) status_d[T_BIT] = 1'b1;
    if (cmp_wr)    status_d[T_BIT] = 1'b0;
    if (ipi_wr)    status_d[I_BIT] = wr_data[0];
    if (host_wr)   status_d[H_BIT] = |wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      host_q   <= '0;
    end else begin
      status_q <= status_d;
      if (host_wr) host_q <= wr_data;
    end
  end

  assign status_o = status_q;
  assign host_o   = host_q;
  assign pend_o   = status_q[PEND_LSB +: IRQ_N];
  assign mask_o   = status_q[MASK_LSB +: IRQ_N];
  assign et_o     = status_q[ET_BIT];

  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[15:9] == '0);

  p_hit_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_hit && !cmp_wr) |=> status_q[T_BIT]);

  p_cmp_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !status_q[T_BIT]);

  p_ipi_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_wr |=> (status_q[I_BIT] == $past(wr_data[0])));

  p_host_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (status_q[H_BIT] == ($past(wr_data) != '0)));
endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter
  import intr_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] pend,
  input  logic [IRQ_N-1:0] mask,
  input  logic             et,
  output logic             irq_req,
  output logic [IRQ_W-1:0] irq_line
);
  logic [IRQ_N-1:0] live;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_live
    assign live[g] = pend[g] & mask[g];
  end

  assign irq_req  = et && (|live);
  assign irq_line = irq_req ? top_index(live) : '0;

  p_line_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend[irq_line] && mask[irq_line]));

  p_timer_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (et && pend[IRQ_TIMER] && mask[IRQ_TIMER]) |-> (irq_line == IRQ_W'(IRQ_TIMER)));

  p_idle_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_line == '0));

  p_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !et |-> !irq_req);
endmodule

// File: rtl/intr_status_ctl.sv
module intr_status_ctl
  import intr_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  output logic             irq_req,
  output logic [IRQ_W-1:0] irq_line
);
  logic status_wr, cnt_wr, cmp_wr, ipi_wr, host_wr;
  logic timer_hit;
  logic [XLEN-1:0] count_v, cmp_v, status_v, host_v;
  logic [IRQ_N-1:0] pend_v, mask_v;
  logic et_v;

  assign status_wr = wr_en && (wr_idx == REG_STATUS);
  assign cnt_wr    = wr_en && (wr_idx == REG_COUNT);
  assign cmp_wr    = wr_en && (wr_idx == REG_COMPARE);
  assign ipi_wr    = wr_en && (wr_idx == REG_IPI_CLR);
  assign host_wr   = wr_en && (wr_idx == REG_HOST_IN);

  ic_timer u_timer (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr),
    .wr_data(wr_data), .count_o(count_v), .cmp_o(cmp_v), .timer_hit(timer_hit)
  );

  ic_status u_status (
    .clk(clk), .rst_n(rst_n), .status_wr(status_wr), .ipi_wr(ipi_wr),
    .host_wr(host_wr), .cmp_wr(cmp_wr), .timer_hit(timer_hit),
    .wr_data(wr_data), .status_o(status_v), .host_o(host_v),
    .pend_o(pend_v), .mask_o(mask_v), .et_o(et_v)
  );

  ic_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend_v), .mask(mask_v), .et(et_v),
    .irq_req(irq_req), .irq_line(irq_line)
  );

  always_comb begin
    unique case (rd_idx)
      REG_STATUS:  rd_data = status_v;
      REG_COUNT:   rd_data = count_v;
      REG_COMPARE: rd_data = cmp_v;
      REG_HOST_IN: rd_data = host_v;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: tb/intr_status_ctl_tb.sv
module intr_status_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        irq_req;
  logic [2:0]  irq_line;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [4:0]  idx;
    logic [31:0] data;
    bit          chk_irq;
    logic        req;
    logic [2:0]  line;
    string       tag;
  } item_t;

  item_t q[$];
  event go, done;

  intr_status_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .irq_req(irq_req), .irq_line(irq_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(go);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        rd_idx = it.idx;
        #1;
        checks++;
        if (rd_data !== it.data) begin
          errors++;
          $display("FAIL %s: reg %0d act=%h exp=%h", it.tag, it.idx, rd_data, it.data);
        end
        if (it.chk_irq) begin
          checks++;
          if (irq_req !== it.req || irq_line !== it.line) begin
            errors++;
            $display("FAIL %s: irq act=%b/%0d exp=%b/%0d", it.tag, irq_req, irq_line,
                     it.req, it.line);
          end
        end
      end
      ->done;
    end
  end

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic exp_reg(input logic [4:0] idx, input logic [31:0] d, input string tag);
    item_t it;
    it.idx = idx; it.data = d; it.chk_irq = 1'b0; it.req = 1'b0; it.line = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_irq(input logic [4:0] idx, input logic [31:0] d, input logic r,
                         input logic [2:0] l, input string tag);
    item_t it;
    it.idx = idx; it.data = d; it.chk_irq = 1'b1; it.req = r; it.line = l; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic flush();
    fork
      @(done);
      ->go;
    join
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    exp_irq(5'd0, 32'h0, 1'b0, 3'd0, "R10 status after reset");
    exp_reg(5'd5, 32'h0, "R10 compare after reset");
    exp_reg(5'd31, 32'h0, "R10 host after reset");
    flush();

    // R1 reserved bits, R3 priority with everything pending
    wr(5'd0, 32'hFFFF_FFFF);
    exp_irq(5'd0, 32'hFFFF_01FF, 1'b1, 3'd7, "R1 R3 all ones write");
    flush();

    // R2 nothing pending
    wr(5'd0, 32'h00E0_0001);
    exp_irq(5'd0, 32'h00E0_0001, 1'b0, 3'd0, "R2 no pending");
    flush();

    // R7 inter-processor set then clear
    wr(5'd8, 32'h0000_0001);
    exp_irq(5'd0, 32'h20E0_0001, 1'b1, 3'd5, "R7 ipi set");
    flush();
    wr(5'd8, 32'h0000_0002);
    exp_irq(5'd0, 32'h00E0_0001, 1'b0, 3'd0, "R7 ipi clear on bit0 zero");
    flush();

    // R8 host message, R3 host over ipi
    wr(5'd8, 32'h0000_0001);
    wr(5'd31, 32'h0000_0055);
    exp_irq(5'd0, 32'h60E0_0001, 1'b1, 3'd6, "R8 R3 host pending beats ipi");
    exp_reg(5'd31, 32'h0000_0055, "R8 host value stored");
    flush();
    wr(5'd31, 32'h0);
    exp_irq(5'd0, 32'h20E0_0001, 1'b1, 3'd5, "R8 host zero clears");
    flush();

    // R2 global enable off, then mask excludes pending line
    wr(5'd0, 32'h20E0_0000);
    exp_irq(5'd0, 32'h20E0_0000, 1'b0, 3'd0, "R2 enable off");
    flush();
    wr(5'd0, 32'h2040_0001);
    exp_irq(5'd0, 32'h2040_0001, 1'b0, 3'd0, "R2 masked out");
    flush();

    // R4 R5 timer crossing
    wr(5'd0, 32'h0080_0001);
    wr(5'd5, 32'd100);
    wr(5'd4, 32'd90);
    exp_reg(5'd4, 32'd90, "R4 count load");
    flush();
    tick(9);
    exp_irq(5'd0, 32'h0080_0001, 1'b0, 3'd0, "R5 before crossing");
    exp_reg(5'd4, 32'd99, "R4 count steps");
    flush();
    tick(1);
    exp_irq(5'd0, 32'h8080_0001, 1'b1, 3'd7, "R5 crossing sets timer");
    exp_reg(5'd4, 32'd100, "R4 count at compare");
    flush();

    // R6 compare write clears timer
    wr(5'd5, 32'd200);
    exp_irq(5'd0, 32'h0080_0001, 1'b0, 3'd0, "R6 compare write clears");
    exp_reg(5'd5, 32'd200, "R6 compare stored");
    flush();

    // R9 status write in the same clock as a timer hit
    wr(5'd5, 32'd50);
    wr(5'd4, 32'd40);
    tick(9);
    wr(5'd0, 32'h0000_0001);
    exp_irq(5'd0, 32'h8000_0001, 1'b0, 3'd0, "R9 timer applied over write");
    flush();

    // R5 wrap does not match; later crossing does
    wr(5'd5, 32'd5);
    wr(5'd4, 32'hFFFF_FFFE);
    exp_reg(5'd0, 32'h0000_0001, "R6 clear before wrap test");
    flush();
    tick(3);
    exp_reg(5'd0, 32'h0000_0001, "R5 wrap no match");
    exp_reg(5'd4, 32'd1, "R4 count wrapped");
    flush();
    tick(4);
    exp_reg(5'd0, 32'h8000_0001, "R5 crossing after wrap");
    flush();

    wr(5'd5, 32'hFFFF_0000);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule